// File: doc/BRIEF.md
# Filtered Input Change Detector

The block watches four general-purpose input pins and records which of them has moved to a new, stable level. Each pin is first brought into the clock domain by a two-flop synchronizer. It is then compared against its current filtered level on every pulse of a slow sample tick. A new level is accepted only after it has differed from the filtered level on two ticks in a row. Both rising and falling transitions count. Each acceptance sets a sticky change flag for that pin.

Software sees a single 8-bit status value. The upper nibble holds the change flags and the lower nibble holds the filtered pin levels. A one-cycle read strobe marks the cycle in which software samples that value, and the flags clear on the next clock edge. A four-bit enable mask chooses which pins' flags can raise the shared interrupt output. The sample tick comes from an external divider; its nominal ratio to the clock (96 by default) is the parameter `TICK_RATIO`.

Top module: `chg_monitor`

## Requirements
- R1: After reset is released and three clock cycles have passed with steady pins, `chg_reg_o[3:0]` equals the pin levels, `chg_reg_o[7:4]` is 0 and `irq_o` is 0. Reset by itself sets no flag.
- R2: A pin level that differs from the filtered level on only one sample tick, and matches it again on the next tick, is rejected. The filtered level and the flag stay unchanged. Between ticks the filtered levels do not change.
- R3: A pin level that differs from the filtered level on two consecutive ticks is accepted at the second tick. Acceptance works for both 0→1 and 1→0.
- R4: The register layout is fixed. Bit 4+i is the change flag of pin i, and bit i is the filtered level of pin i, for i = 0..3.
- R5: A change flag stays set across later ticks and further changes until a read strobe occurs.
- R6: A read strobe (`rd_i` high for one cycle) leaves the value in that cycle unchanged. From the next cycle on, all flags with no new acceptance are 0.
- R7: When a change is accepted in the same cycle as a read strobe, that pin's flag is 1 after the edge, and the other flags are cleared.
- R8: `irq_o` is 1 exactly when some flag i is set and `irq_mask_i[i]` is 1. With the mask at 0, `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 4 | Raw, asynchronous input pins |
| tick_i | input | 1 | Sample-tick enable, one cycle wide, about every TICK_RATIO cycles |
| rd_i | input | 1 | Read strobe for the change register |
| irq_mask_i | input | 4 | Per-pin enable for the shared interrupt |
| chg_reg_o | output | 8 | {change flags 3..0, filtered levels 3..0} |
| irq_o | output | 1 | Shared input-change interrupt |

## Verification
A read strobe can coincide with the sample tick that accepts a change, so clearing and setting hit the flags in the same cycle. The bench provokes this in directed form and also at random: it raises `rd_i` during the tick cycle of a second qualifying sample. The outcome is judged against a bench model that applies the clear first and the set second. The accepting pin's flag must survive, and every other flag must drop.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned INIT_CYCLES = SYNC_STAGES + 1;

  typedef enum logic {
    FS_STEADY  = 1'b0,
    FS_PENDING = 1'b1
  } filt_state_e;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = chg_pkg::SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] pipe_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[b] <= '0;
      else         pipe_q[b] <= {pipe_q[b][STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe_q[b][STAGES-1];
  end
endmodule

// File: rtl/chg_filter.sv
module chg_filter
  import chg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  input  logic tick_i,
  input  logic sample_i,
  output logic level_o,
  output logic accept_o
);
  filt_state_e state_q, state_d;
  logic        level_q, level_d;
  logic        differs;

  assign differs = sample_i ^ level_q;

  always_comb begin
    state_d  = state_q;
    level_d  = level_q;
    accept_o = 1'b0;
    if (!init_done_i) begin
      // track the synchronized pin so reset raises no change
      level_d = sample_i;
      state_d = FS_STEADY;
    end else if (tick_i) begin
      if (!differs) begin
        state_d = FS_STEADY;
      end else if (state_q == FS_PENDING) begin
        level_d  = sample_i;
        state_d  = FS_STEADY;
        accept_o = 1'b1;
      end else begin
        state_d = FS_PENDING;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_STEADY;
      level_q <= 1'b0;
    end else begin
      state_q <= state_d;
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

  a_r2_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_i && !tick_i) |=> $stable(level_o));

  a_r2_single_sample_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_i && tick_i && state_q == FS_STEADY) |=> $stable(level_o));

  a_r3_accept_flips_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (level_o != $past(level_o)));
endmodule

// File: rtl/chg_flags.sv
module chg_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] flags_q;

  // clear first, then set: a same-cycle acceptance survives the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & {WIDTH{~clr_i}}) | set_i;
  end

  assign flags_o = flags_q;

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (flags_o == '0));

  a_r7_set_survives_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/chg_monitor.sv
module chg_monitor
  import chg_pkg::*;
#(
  parameter int unsigned N_IN       = 4,
  parameter int unsigned TICK_RATIO = 96
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] pins_i,
  input  logic            tick_i,
  input  logic            rd_i,
  input  logic [N_IN-1:0] irq_mask_i,
  output logic [2*N_IN-1:0] chg_reg_o,
  output logic            irq_o
);
  localparam int unsigned INIT_W = $clog2(INIT_CYCLES + 1);
  localparam int unsigned GAP_W  = $clog2(TICK_RATIO + 1);

  logic [N_IN-1:0]   pins_sync;
  logic [N_IN-1:0]   level;
  logic [N_IN-1:0]   accept;
  logic [N_IN-1:0]   flags;
  logic [INIT_W-1:0] init_cnt_q;
  logic              init_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           init_cnt_q <= '0;
    else if (!init_done)   init_cnt_q <= init_cnt_q + 1'b1;
  end
  assign init_done = (init_cnt_q == INIT_W'(INIT_CYCLES));

  chg_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pins_sync)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_ch
    chg_filter u_filt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .init_done_i (init_done),
      .tick_i      (tick_i),
      .sample_i    (pins_sync[i]),
      .level_o     (level[i]),
      .accept_o    (accept[i])
    );
  end

  chg_flags #(.WIDTH(N_IN)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (accept),
    .clr_i   (rd_i),
    .flags_o (flags)
  );

  assign chg_reg_o = {flags, level};
  assign irq_o     = |(flags & irq_mask_i);

  // tick spacing check against the divider ratio
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          gap_q <= '0;
    else if (tick_i)                      gap_q <= '0;
    else if (gap_q != GAP_W'(TICK_RATIO)) gap_q <= gap_q + 1'b1;
  end

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && init_done) |-> (gap_q >= GAP_W'(TICK_RATIO - 1)));

  a_r1_no_flag_from_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done |-> (chg_reg_o[2*N_IN-1:N_IN] == '0));

  a_r8_mask_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mask_i == '0) |-> !irq_o);

  a_r8_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (chg_reg_o[2*N_IN-1:N_IN] != '0));
endmodule

// File: tb/sim_chg_monitor.sv
module sim_chg_monitor;
  localparam int unsigned N   = 4;
  localparam int unsigned GAP = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N-1:0]   pins_i = '0;
  logic           tick_i = 1'b0;
  logic           rd_i = 1'b0;
  logic [N-1:0]   irq_mask_i = '0;
  logic [2*N-1:0] chg_reg_o;
  logic           irq_o;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] m_lvl, m_flag, m_pend;

  always #2.5 clk_i = ~clk_i;

  chg_monitor #(.N_IN(N), .TICK_RATIO(GAP)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .tick_i(tick_i),
    .rd_i(rd_i), .irq_mask_i(irq_mask_i), .chg_reg_o(chg_reg_o), .irq_o(irq_o)
  );

  function automatic logic [2*N-1:0] exp_reg();
    return {m_flag, m_lvl};
  endfunction

  function automatic logic exp_irq();
    return |(m_flag & irq_mask_i);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check(req, chg_reg_o, exp_reg());
    check({req, " irq R8"}, {7'd0, irq_o}, {7'd0, exp_irq()});
  endtask

  // model: read clears first, then tick evaluation sets
  task automatic model_tick(input logic rd);
    if (rd) m_flag = '0;
    for (int i = 0; i < N; i++) begin
      if (pins_i[i] != m_lvl[i]) begin
        if (m_pend[i]) begin
          m_lvl[i] = pins_i[i]; m_flag[i] = 1'b1; m_pend[i] = 1'b0;
        end else m_pend[i] = 1'b1;
      end else m_pend[i] = 1'b0;
    end
  endtask

  // set pins, wait the tick gap, pulse tick (optionally with read), check
  task automatic step(input logic [N-1:0] p, input logic rd, input string req);
    @(negedge clk_i);
    pins_i = p;
    repeat (GAP - 1) @(negedge clk_i);
    tick_i = 1'b1;
    rd_i   = rd;
    if (rd) check({req, " read value R6"}, chg_reg_o, exp_reg());
    @(negedge clk_i);
    tick_i = 1'b0;
    rd_i   = 1'b0;
    model_tick(rd);
    check_all(req);
  endtask

  task automatic do_read(input string req);
    @(negedge clk_i);
    rd_i = 1'b1;
    check({req, " read value R6"}, chg_reg_o, exp_reg());
    @(negedge clk_i);
    rd_i = 1'b0;
    m_flag = '0;
    check_all(req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [N-1:0] p;
    void'($urandom(32'd2024));
    pins_i = 4'b1010;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    m_lvl = 4'b1010; m_flag = '0; m_pend = '0;
    repeat (GAP + 2) @(negedge clk_i);
    // R1: levels follow pins, no flag, no irq; R4 layout
    irq_mask_i = 4'hF;
    check_all("R1 reset state R4");

    // R2: glitch on pin 0 for one tick only
    step(4'b1011, 1'b0, "R2 first sample");
    step(4'b1010, 1'b0, "R2 glitch rejected");

    // R3: rising on pin 0 over two ticks
    step(4'b1011, 1'b0, "R3 rise pending");
    step(4'b1011, 1'b0, "R3 rise accepted R4");
    // R3: falling on pin 3
    step(4'b0011, 1'b0, "R3 fall pending");
    step(4'b0011, 1'b0, "R3 fall accepted");
    // R5: flags persist across idle ticks
    step(4'b0011, 1'b0, "R5 sticky");
    // R8: mask gating
    irq_mask_i = 4'b0110;
    @(negedge clk_i);
    check("R8 masked off", {7'd0, irq_o}, 8'd0);
    irq_mask_i = 4'b1000;
    @(negedge clk_i);
    check("R8 masked on", {7'd0, irq_o}, 8'd1);
    // R6: read clears
    do_read("R6 clear");
    // R7: accept in the same cycle as a read
    step(4'b0111, 1'b0, "R7 pending");
    irq_mask_i = 4'hF;
    do_read("R6 clear again");
    step(4'b0111, 1'b0, "R7 pending2");
    step(4'b0101, 1'b0, "R7 pin1 pending");
    step(4'b0101, 1'b1, "R7 accept with read");

    // random phase
    p = pins_i;
    for (int k = 0; k < 300; k++) begin
      if ($urandom % 3 == 0) p = p ^ N'($urandom);
      irq_mask_i = N'($urandom);
      step(p, ($urandom % 4) == 0, "R3 random");
      if ($urandom % 6 == 0) do_read("R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule